// File: doc/BRIEF.md
# Auto-Reload 8-bit Timer/Counter

This block is an 8-bit up counter paired with a preset value that it reloads automatically. A 4-bit command word selects a pulse source and an operating mode. The pulse source is one of three internal prescaled tick inputs or rising edges on an external pin. The modes are: stopped, plain reload timer (an event counter when the external source is chosen), tone output, and pulse-width measurement. When the counter passes its maximum value it reloads the preset and raises a one-cycle interrupt request. In tone mode an output flip-flop also toggles on each wrap, which gives a square wave at half the wrap rate.

Software reaches the block through a nibble-wide register port. Writing the high preset nibble only stages it. Writing the low nibble commits both nibbles together as the new effective preset, so the high nibble goes in first. A new preset does not stop the counter: it is used at the next wrap. The current count can be read back as two nibbles. Stopping the counter freezes its value so that the two reads are consistent.

Top module: `reload_tc8`

## Requirements
- R1: After a synchronous active-low reset, the count, the staged nibble, the effective preset and the command are all zero, and `irq` and `tone_out` are low.
- R2: The command word is cmd[3:2] = mode and cmd[1:0] = source. Mode 01 is timer, 10 is tone, 11 is pulse width and 00 is off. In timer or tone mode, source values 0, 1 and 2 make the count advance by exactly one on each cycle in which `int_tick[source]` is high. The other tick inputs have no effect.
- R3: In timer or tone mode with source 3, the count advances by one for each rising edge of `ext_in`. The edge takes effect three clock edges after it is first sampled, because of two synchronizer stages and an edge detector.
- R4: A write to address 1 stores the high preset nibble without changing the effective preset. A write to address 0 sets the effective preset to {staged high nibble, written low nibble}.
- R5: A write to address 2 (the command) that changes the mode from 00 to a nonzero value loads the effective preset into the counter on that clock edge. A command write between two nonzero modes does not reload.
- R6: When a count step occurs at value 0xFF, the counter loads the effective preset and `irq` is high for the following cycle. `irq` is low at all other times.
- R7: A preset committed while the counter runs leaves the current count unchanged and is the value loaded at the next wrap.
- R8: In tone mode `tone_out` toggles on every wrap. In any other mode it returns to zero one cycle after the mode changes and stays there.
- R9: In pulse-width mode the count advances on the selected internal tick only while the synchronized `ext_in` is high. Source 3 selects `int_tick[0]` in this mode.
- R10: In mode 00 the count holds its value. Reads at `rd_addr` 0, 1, 2 and 3 return the count's low nibble, the count's high nibble, the command word and zero respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 preset low, 1 preset high, 2 command |
| wr_data | input | 4 | Write data nibble |
| rd_addr | input | 2 | Read address: 0 count low, 1 count high, 2 command |
| rd_data | output | 4 | Read data nibble (combinational) |
| int_tick | input | 3 | Internal prescaled single-cycle tick pulses |
| ext_in | input | 1 | External asynchronous count/gate input |
| irq | output | 1 | One-cycle wrap interrupt request |
| tone_out | output | 1 | Square-wave output in tone mode |

## Verification
A wrong staged nibble or effective preset stays hidden until the next wrap. It then shows up as a wrong value read back right after `irq`, so the bench drives wraps often with small and large presets. A missed or extra step shows at the read port in the cycle after the tick. A synchronizer error shows as an event or gate that lands one cycle early or late. A stuck tone flip-flop shows on `tone_out` at the first wrap in tone mode, or one cycle after leaving tone mode. A reference model updated on the same edges is compared with `irq`, `tone_out` and the read port every cycle.

// File: rtl/tc8_pkg.sv
// Shared encodings for the auto-reload 8-bit timer/counter.
// Assumes a nibble-wide register port with a 2-bit address.
package tc8_pkg;
    localparam int ADDR_W = 2;
    localparam int CMD_W  = 4;

    localparam logic [ADDR_W-1:0] REG_PLO = 2'd0;
    localparam logic [ADDR_W-1:0] REG_PHI = 2'd1;
    localparam logic [ADDR_W-1:0] REG_CMD = 2'd2;

    localparam logic [1:0] SEL_EXT = 2'd3;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_TIMER  = 2'd1,
        MODE_TONE   = 2'd2,
        MODE_PWIDTH = 2'd3
    } tc_mode_e;
endpackage

// File: rtl/tc8_regs.sv
// Register file: staged high preset nibble, effective preset, command word,
// start detection and read-back multiplexer.
// Assumes NIB_W >= CMD_W and one write per cycle.
module tc8_regs
    import tc8_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [NIB_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [2*NIB_W-1:0]   count,
    output logic [2*NIB_W-1:0]   preset,
    output tc_mode_e             mode,
    output logic [1:0]           sel,
    output logic                 start,
    output logic [NIB_W-1:0]     rd_data
);
    localparam int CNT_W = 2 * NIB_W;

    logic [NIB_W-1:0] hi_stage_q;
    logic [CNT_W-1:0] preset_q;
    logic [CMD_W-1:0] cmd_q;
    logic             wr_plo, wr_phi, wr_cmd;
    tc_mode_e         new_mode;

    // Decode the write strobe per address.
    always_comb begin
        wr_plo = wr_en && (wr_addr == REG_PLO);
        wr_phi = wr_en && (wr_addr == REG_PHI);
        wr_cmd = wr_en && (wr_addr == REG_CMD);
    end

    // Hold the staged nibble, the committed preset and the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_stage_q <= '0;
            preset_q   <= '0;
            cmd_q      <= '0;
        end else begin
            if (wr_phi) hi_stage_q <= wr_data;
            if (wr_plo) preset_q   <= {hi_stage_q, wr_data};
            if (wr_cmd) cmd_q      <= wr_data[CMD_W-1:0];
        end
    end

    // Split the command and flag a start when leaving the off mode.
    always_comb begin
        mode     = tc_mode_e'(cmd_q[3:2]);
        sel      = cmd_q[1:0];
        new_mode = tc_mode_e'(wr_data[3:2]);
        start    = wr_cmd && (mode == MODE_OFF) && (new_mode != MODE_OFF);
        preset   = preset_q;
    end

    // Return the count nibbles or the command word.
    always_comb begin
        case (rd_addr)
            REG_PLO: rd_data = count[NIB_W-1:0];
            REG_PHI: rd_data = count[CNT_W-1:NIB_W];
            REG_CMD: rd_data = NIB_W'(cmd_q);
            default: rd_data = '0;
        endcase
    end

    // R4
    stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phi |=> $stable(preset_q));

    // R5
    start_from_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && mode != MODE_OFF) |-> !start);
endmodule

// File: rtl/tc8_pulse.sv
// Pulse selection: synchronizes the external pin, detects its rising edge,
// picks the internal tick and forms one count-step strobe per cycle.
// Assumes internal ticks are single-cycle pulses in the clk domain.
module tc8_pulse
    import tc8_pkg::*;
#(
    parameter int NUM_INT     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_INT-1:0] int_tick,
    input  logic               ext_in,
    input  tc_mode_e           mode,
    input  logic [1:0]         sel,
    output logic               step
);
    localparam int NSEL = 4;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   ext_lvl, ext_rise, int_pick;
    logic [NSEL-1:0]        tick_pad;

    // Bring the external pin into the clock domain and remember its last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Map each source code to an internal tick; missing ones fall back to tick 0.
    for (genvar i = 0; i < NSEL; i++) begin : g_pad
        if (i < NUM_INT) begin : g_real
            assign tick_pad[i] = int_tick[i];
        end else begin : g_fill
            assign tick_pad[i] = int_tick[0];
        end
    end

    // Form the step strobe for the active mode.
    always_comb begin
        ext_lvl  = sync_q[SYNC_STAGES-1];
        ext_rise = ext_lvl & ~last_q;
        int_pick = tick_pad[sel];
        case (mode)
            MODE_TIMER,
            MODE_TONE:   step = (sel == SEL_EXT) ? ext_rise : int_pick;
            MODE_PWIDTH: step = int_pick & ext_lvl;
            default:     step = 1'b0;
        endcase
    end

    // R3
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise);
endmodule

// File: rtl/tc8_core.sv
// Counter core: preset load on start, increment on step, reload and
// interrupt on wrap, tone flip-flop in tone mode.
// Assumes start has priority over a step in the same cycle.
module tc8_core
    import tc8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             start,
    input  tc_mode_e         mode,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             tone
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic wrap;

    // Detect a step that carries past the maximum.
    always_comb wrap = step && !start && (count == CNT_MAX);

    // Advance, reload and raise the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= wrap;
            if (start)      count <= preset;
            else if (wrap)  count <= preset;
            else if (step)  count <= count + 1'b1;
        end
    end

    // Toggle the tone output on wraps in tone mode, clear it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                 tone <= 1'b0;
        else if (mode != MODE_TONE) tone <= 1'b0;
        else if (wrap)              tone <= ~tone;
    end

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && count == CNT_MAX) |=> (irq && count == $past(preset)));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && count != CNT_MAX) |=> (count == $past(count) + 1'b1));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF && !start) |=> $stable(count));

    // R8
    tone_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_TONE) |=> !tone);

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(step));
endmodule

// File: rtl/reload_tc8.sv
// Top of the auto-reload 8-bit timer/counter: register port, pulse
// selection and counter core. Assumes all inputs except ext_in are synchronous to clk.
module reload_tc8
    import tc8_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter int NUM_INT     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [NIB_W-1:0]   wr_data,
    input  logic [1:0]         rd_addr,
    output logic [NIB_W-1:0]   rd_data,
    input  logic [NUM_INT-1:0] int_tick,
    input  logic               ext_in,
    output logic               irq,
    output logic               tone_out
);
    localparam int CNT_W = 2 * NIB_W;

    logic [CNT_W-1:0] count, preset;
    tc_mode_e         mode;
    logic [1:0]       sel;
    logic             start, step;

    tc8_regs #(.NIB_W(NIB_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .count(count),
        .preset(preset), .mode(mode), .sel(sel), .start(start),
        .rd_data(rd_data)
    );

    tc8_pulse #(.NUM_INT(NUM_INT), .SYNC_STAGES(SYNC_STAGES)) pulse_i (
        .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .ext_in(ext_in),
        .mode(mode), .sel(sel), .step(step)
    );

    tc8_core #(.CNT_W(CNT_W)) core_i (
        .clk(clk), .rst_n(rst_n), .step(step), .start(start), .mode(mode),
        .preset(preset), .count(count), .irq(irq), .tone(tone_out)
    );
endmodule

// File: tb/reload_tc8_tb_top.sv
module reload_tc8_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [3:0] rd_data;
    logic [2:0] int_tick = '0;
    logic       ext_in = 1'b0;
    logic       irq, tone_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit mon_on  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reload_tc8 dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .int_tick(int_tick), .ext_in(ext_in), .irq(irq), .tone_out(tone_out)
    );

    // Reference model built from the requirements.
    logic [7:0] m_cnt, m_pre;
    logic [3:0] m_hi, m_cmd;
    logic       m_s1, m_s2, m_prev, m_irq, m_tone;
    logic       m_step, m_start, m_pick, m_wrap;
    logic [1:0] m_mode, m_sel;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= '0; m_pre <= '0; m_hi <= '0; m_cmd <= '0;
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_irq <= 0; m_tone <= 0;
        end else begin
            m_mode  = m_cmd[3:2];
            m_sel   = m_cmd[1:0];
            m_pick  = (m_sel == 2'd3) ? int_tick[0] : int_tick[m_sel];
            if (m_mode == 2'd0)      m_step = 1'b0;
            else if (m_mode == 2'd3) m_step = m_pick & m_s2;
            else if (m_sel == 2'd3)  m_step = m_s2 & ~m_prev;
            else                     m_step = int_tick[m_sel];
            m_start = wr_en && wr_addr == 2'd2 && m_mode == 2'd0 && wr_data[3:2] != 2'd0;
            m_wrap  = m_step && !m_start && m_cnt == 8'hFF;
            m_s1 <= ext_in; m_s2 <= m_s1; m_prev <= m_s2;
            m_irq <= m_wrap;
            if (m_start)     m_cnt <= m_pre;
            else if (m_wrap) m_cnt <= m_pre;
            else if (m_step) m_cnt <= m_cnt + 8'd1;
            if (m_mode != 2'd2) m_tone <= 1'b0;
            else if (m_wrap)    m_tone <= ~m_tone;
            if (wr_en && wr_addr == 2'd1) m_hi <= wr_data;
            if (wr_en && wr_addr == 2'd0) m_pre <= {m_hi, wr_data};
            if (wr_en && wr_addr == 2'd2) m_cmd <= wr_data;
        end
    end

    function automatic logic [3:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return m_cnt[3:0];
            2'd1:    return m_cnt[7:4];
            2'd2:    return m_cmd;
            default: return 4'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (mon_on) begin
            #3;
            chk(irq == m_irq, "R6 irq vs model", irq, m_irq);
            chk(tone_out == m_tone, "R8 tone vs model", tone_out, m_tone);
            chk(rd_data == exp_rd(rd_addr), "R10 readback vs model", rd_data, exp_rd(rd_addr));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk); int_tick[idx] = 1'b1;
        @(negedge clk); int_tick = '0;
    endtask

    task automatic peek(output logic [7:0] v);
        rd_addr = 2'd0; #1; v[3:0] = rd_data;
        rd_addr = 2'd1; #1; v[7:4] = rd_data;
    endtask

    task automatic expect_cnt(input logic [7:0] e, input string tag);
        logic [7:0] v;
        peek(v);
        chk(v == e, tag, v, e);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] v4;
        void'($urandom(32'h5EED_0C8));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: reset state
        @(negedge clk);
        expect_cnt(8'h00, "R1 count after reset");
        rd_addr = 2'd2; #1; v4 = rd_data;
        chk(v4 == 4'h0, "R1 command after reset", v4, 0);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        chk(tone_out == 1'b0, "R1 tone after reset", tone_out, 0);

        // R4: high nibble only staged
        wr(2'd1, 4'hA);
        wr(2'd2, 4'b0100);
        @(negedge clk); expect_cnt(8'h00, "R4 staged high not applied");
        wr(2'd0, 4'h5);
        wr(2'd2, 4'b0000);
        wr(2'd2, 4'b0100);
        @(negedge clk); expect_cnt(8'hA5, "R5 start loads preset");

        // R2: selected tick counts, others ignored
        pulse(0); pulse(0); pulse(0);
        @(negedge clk); expect_cnt(8'hA8, "R2 tick0 counts");
        pulse(1); pulse(2);
        @(negedge clk); expect_cnt(8'hA8, "R2 other ticks ignored");
        wr(2'd2, 4'b0110);
        @(negedge clk); expect_cnt(8'hA8, "R5 no reload between running modes");
        pulse(2);
        @(negedge clk); expect_cnt(8'hA9, "R2 tick2 counts");

        // R10: off mode holds, command readback
        wr(2'd2, 4'b0000);
        pulse(0); pulse(2);
        @(negedge clk); expect_cnt(8'hA9, "R10 hold in off mode");
        rd_addr = 2'd3; #1; v4 = rd_data;
        chk(v4 == 4'h0, "R10 address 3 reads zero", v4, 0);

        // R6: wrap reloads and raises irq
        wr(2'd1, 4'hF); wr(2'd0, 4'hE);
        wr(2'd2, 4'b0100);
        pulse(0);
        chk(irq == 1'b0, "R6 no irq before wrap", irq, 0);
        pulse(0);
        chk(irq == 1'b1, "R6 irq on wrap", irq, 1);
        expect_cnt(8'hFE, "R6 reload value");
        @(negedge clk);
        chk(irq == 1'b0, "R6 irq one cycle", irq, 0);

        // R7: new preset while running applies at next wrap
        wr(2'd1, 4'h3); wr(2'd0, 4'h0);
        @(negedge clk); expect_cnt(8'hFE, "R7 count untouched by preset write");
        pulse(0); pulse(0);
        expect_cnt(8'h30, "R7 new preset at wrap");

        // R8: tone mode
        wr(2'd2, 4'b0000);
        wr(2'd1, 4'hF); wr(2'd0, 4'hF);
        wr(2'd2, 4'b1001);
        chk(tone_out == 1'b0, "R8 tone low at start", tone_out, 0);
        pulse(1);
        chk(tone_out == 1'b1, "R8 tone toggles on wrap", tone_out, 1);
        pulse(1);
        chk(tone_out == 1'b0, "R8 tone toggles back", tone_out, 0);
        pulse(1);
        wr(2'd2, 4'b0101);
        @(negedge clk);
        chk(tone_out == 1'b0, "R8 tone cleared leaving tone mode", tone_out, 0);

        // R3: external edges in event mode
        wr(2'd2, 4'b0000);
        wr(2'd1, 4'h1); wr(2'd0, 4'h0);
        wr(2'd2, 4'b0111);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); ext_in = 1'b1;
            repeat (4) @(negedge clk);
            ext_in = 1'b0;
            repeat (4) @(negedge clk);
        end
        pulse(0);
        @(negedge clk); expect_cnt(8'h12, "R3 two external edges counted");

        // R9: pulse-width gating
        wr(2'd2, 4'b0000);
        wr(2'd2, 4'b1111);
        pulse(0); pulse(0);
        @(negedge clk); expect_cnt(8'h10, "R9 gate low blocks ticks");
        ext_in = 1'b1;
        repeat (3) @(negedge clk);
        pulse(0); pulse(0); pulse(0);
        @(negedge clk); expect_cnt(8'h13, "R9 ticks counted while gate high");
        ext_in = 1'b0;

        // Random phase checked against the model every cycle.
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            wr_en    = ($urandom % 10) == 0;
            wr_addr  = 2'($urandom % 4);
            wr_data  = 4'($urandom);
            int_tick = 3'($urandom) & {3{($urandom % 2) == 0}};
            if (($urandom % 7) == 0) ext_in = ~ext_in;
            rd_addr  = 2'($urandom % 4);
        end
        @(negedge clk); wr_en = 1'b0; int_tick = '0;
        repeat (4) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule